// File: doc/BRIEF.md
# Period-Register PWM with Fractional Duty

This block drives one pulse-width-modulated output. An 8-bit timer runs from zero up to a programmable top value and then restarts. Below the timer sit two sub-count bits that advance on every clock. Together they form a 10-bit extended count. The timer therefore steps once every four clocks, and one period lasts 4*(top+1) clocks. The duty value has two parts: a coarse byte that is compared with the timer, and a 2-bit fine part that is compared with the sub-count. The output is high from the first clock of a period until the extended count reaches the duty value.

Software-side writes land in shadow registers. The active top and duty values pick up the shadow contents only on the last clock of a period, or at any time while the block is stopped, so a running period never sees a half-updated setting. There is a second way to write the duty: an 8-bit step-table style byte. Its upper seven bits become the coarse field, and its LSB becomes the upper fine bit. A duty value of zero holds the output low. A duty value beyond the last extended count holds it high for the whole period. A one-clock marker shows the first clock of every period.

Top module: `pwm_frac`

## Requirements
- R1: After reset both outputs are low, the top-value shadow holds 0xFF and the duty shadow holds zero, so the first enabled period lasts 1024 clocks.
- R2: The extended count is {timer, sub}. The sub-count advances every clock and the timer advances every 4 clocks. One period lasts exactly 4*(top+1) clocks, including top = 0 (4 clocks).
- R3: Let D = coarse*4 + fine. When 0 < D <= 4*top+3, the output is high for exactly the first D clocks of each period and low for the rest.
- R4: When D > 4*top+3 (for example coarse = top+1 and fine = 0, or coarse = 0xFF and fine = 3), the output is high for the whole period.
- R5: When D = 0 the output stays low for the whole period, with no pulse on its first clock.
- R6: Each step of the 2-bit fine field adds exactly one clock of high time.
- R7: Writes to the top and duty values do not change the period in progress. They take effect from the first clock of the following period.
- R8: A step-byte write u loads coarse = u>>1 and fine = {u[0], 0}. With top = 0x7C, u = 250 gives 100% duty and u = 101 gives 202 high clocks.
- R9: Dropping the enable clears the count. One clock later the output and the period marker are both low. Raising it again starts a fresh period one clock later.
- R10: The period marker is high for exactly one clock, the first clock of each period.
- R11: A direct duty write and a step-byte write in the same cycle: the direct write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Run enable; low clears the count and holds the output low |
| per_wr_i | input | 1 | Write strobe for the top-value shadow |
| per_data_i | input | 8 | New top value |
| duty_wr_i | input | 1 | Write strobe for the direct duty shadow |
| duty_coarse_i | input | 8 | Coarse duty, compared with the timer |
| duty_fine_i | input | 2 | Fine duty, compared with the sub-count |
| ustep_wr_i | input | 1 | Write strobe for the step-byte duty form |
| ustep_data_i | input | 8 | Step-byte duty value (meaningful up to 250 at top 0x7C) |
| pwm_o | output | 1 | PWM output |
| period_start_o | output | 1 | High on the first clock of each period |

## Verification
The bench probes the two duty extremes. At one end, a design that fires the compare on the reset clock leaks a one-clock pulse at zero duty. At the other, a design that saturates at the top value instead of one past it drops the last few clocks of a nominally full period. Fine steps are swept one at a time, because a design that ignores the sub-count, or compares it in the wrong order, loses or shifts one clock of high time per step. A duty rewrite is issued in the low part of a period: an unbuffered design would then raise the output mid-period. The bench also covers the step-byte mapping, the write priority, the shortest period, and stop/restart, where a design that keeps counting would resume in the middle of an old period.

// File: rtl/pwm_frac_pkg.sv
package pwm_frac_pkg;
  parameter int unsigned TIMER_W_DEF = 8;
  parameter int unsigned FINE_W_DEF  = 2;

  typedef enum logic [1:0] {
    DSRC_HOLD   = 2'd0,
    DSRC_DIRECT = 2'd1,
    DSRC_STEP   = 2'd2
  } duty_src_e;
endpackage

// File: rtl/pwm_frac_regs.sv
module pwm_frac_regs
  import pwm_frac_pkg::*;
#(
  parameter int unsigned TW = TIMER_W_DEF,
  parameter int unsigned FW = FINE_W_DEF,
  localparam int unsigned DW = TW + FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          per_wr,
  input  logic [TW-1:0] per_data,
  input  logic          duty_wr,
  input  logic [TW-1:0] duty_coarse,
  input  logic [FW-1:0] duty_fine,
  input  logic          step_wr,
  input  logic [TW-1:0] step_data,
  input  logic          load,
  output logic [TW-1:0] per_act,
  output logic [DW-1:0] duty_act
);
  logic [TW-1:0] per_sh_q, per_sh_d, per_act_q, per_act_d;
  logic [DW-1:0] duty_sh_q, duty_sh_d, duty_act_q, duty_act_d;
  logic [DW-1:0] step_map;
  duty_src_e     src;

  // step byte: upper bits to coarse, LSB to top fine bit, rest zero
  assign step_map = DW'(step_data) << (FW - 1);

  always_comb begin
    if (duty_wr)      src = DSRC_DIRECT;
    else if (step_wr) src = DSRC_STEP;
    else              src = DSRC_HOLD;
  end

  always_comb begin
    per_sh_d = per_wr ? per_data : per_sh_q;
    unique case (src)
      DSRC_DIRECT: duty_sh_d = {duty_coarse, duty_fine};
      DSRC_STEP:   duty_sh_d = step_map;
      default:     duty_sh_d = duty_sh_q;
    endcase
    per_act_d  = load ? per_sh_q  : per_act_q;
    duty_act_d = load ? duty_sh_q : duty_act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_sh_q   <= '1;
      per_act_q  <= '1;
      duty_sh_q  <= '0;
      duty_act_q <= '0;
    end else begin
      per_sh_q   <= per_sh_d;
      per_act_q  <= per_act_d;
      duty_sh_q  <= duty_sh_d;
      duty_act_q <= duty_act_d;
    end
  end

  assign per_act  = per_act_q;
  assign duty_act = duty_act_q;
endmodule

// File: rtl/pwm_frac_count.sv
module pwm_frac_count
  import pwm_frac_pkg::*;
#(
  parameter int unsigned TW = TIMER_W_DEF,
  parameter int unsigned FW = FINE_W_DEF,
  localparam int unsigned DW = TW + FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [TW-1:0] per_act,
  output logic [DW-1:0] cnt,
  output logic          run,
  output logic          load
);
  logic [DW-1:0] cnt_q, cnt_d, last;
  logic          run_q, run_d, wrap;

  assign last = {per_act, {FW{1'b1}}};
  assign wrap = run_q && (cnt_q == last);
  assign load = !run_q || wrap;

  always_comb begin
    run_d = en;
    if (!en || !run_q || wrap) cnt_d = '0;
    else                       cnt_d = cnt_q + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign cnt = cnt_q;
  assign run = run_q;
endmodule

// File: rtl/pwm_frac_cmp.sv
module pwm_frac_cmp
  import pwm_frac_pkg::*;
#(
  parameter int unsigned TW = TIMER_W_DEF,
  parameter int unsigned FW = FINE_W_DEF,
  localparam int unsigned DW = TW + FW
) (
  input  logic          run,
  input  logic [DW-1:0] cnt,
  input  logic [DW-1:0] duty_act,
  output logic          pwm,
  output logic          period_start
);
  always_comb begin
    pwm          = run && (cnt < duty_act);
    period_start = run && (cnt == '0);
  end
endmodule

// File: rtl/pwm_frac.sv
module pwm_frac
  import pwm_frac_pkg::*;
#(
  parameter int unsigned TW = TIMER_W_DEF,
  parameter int unsigned FW = FINE_W_DEF,
  localparam int unsigned DW = TW + FW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          per_wr_i,
  input  logic [TW-1:0] per_data_i,
  input  logic          duty_wr_i,
  input  logic [TW-1:0] duty_coarse_i,
  input  logic [FW-1:0] duty_fine_i,
  input  logic          ustep_wr_i,
  input  logic [TW-1:0] ustep_data_i,
  output logic          pwm_o,
  output logic          period_start_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_sync_n;
  logic [TW-1:0] per_act;
  logic [DW-1:0] duty_act, cnt;
  logic          run, load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  pwm_frac_regs #(.TW(TW), .FW(FW)) u_regs (
    .clk(clk_i), .rst_n(rst_sync_n),
    .per_wr(per_wr_i), .per_data(per_data_i),
    .duty_wr(duty_wr_i), .duty_coarse(duty_coarse_i), .duty_fine(duty_fine_i),
    .step_wr(ustep_wr_i), .step_data(ustep_data_i),
    .load(load), .per_act(per_act), .duty_act(duty_act)
  );

  pwm_frac_count #(.TW(TW), .FW(FW)) u_count (
    .clk(clk_i), .rst_n(rst_sync_n), .en(en_i),
    .per_act(per_act), .cnt(cnt), .run(run), .load(load)
  );

  pwm_frac_cmp #(.TW(TW), .FW(FW)) u_cmp (
    .run(run), .cnt(cnt), .duty_act(duty_act),
    .pwm(pwm_o), .period_start(period_start_o)
  );
endmodule

// File: rtl/pwm_frac_chk.sv
module pwm_frac_chk
  import pwm_frac_pkg::*;
#(
  parameter int unsigned TW = TIMER_W_DEF,
  parameter int unsigned FW = FINE_W_DEF,
  localparam int unsigned DW = TW + FW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          pwm,
  input logic          period_start,
  input logic          run,
  input logic [DW-1:0] cnt,
  input logic [TW-1:0] per_act,
  input logic [DW-1:0] duty_act
);
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= {per_act, {FW{1'b1}}});

  p_start_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && duty_act != '0) |-> pwm);

  p_full_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && duty_act > {per_act, {FW{1'b1}}}) |-> pwm);

  p_zero_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act == '0) |-> !pwm);

  p_active_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != '0) |-> ($stable(duty_act) && $stable(per_act)));

  p_stop_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pwm && !period_start));

  p_marker_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !period_start);
endmodule

bind pwm_frac pwm_frac_chk #(.TW(TW), .FW(FW)) u_chk (
  .clk(clk_i), .rst_n(rst_sync_n), .en(en_i), .pwm(pwm_o),
  .period_start(period_start_o), .run(run), .cnt(cnt),
  .per_act(per_act), .duty_act(duty_act)
);

// File: tb/sim_pwm_frac.sv
`timescale 1ns/1ps
module sim_pwm_frac;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic per_wr = 1'b0, duty_wr = 1'b0, us_wr = 1'b0;
  logic [7:0] per_d = '0, dc = '0, us_d = '0;
  logic [1:0] df = '0;
  logic pwm, ps;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  pwm_frac u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .per_wr_i(per_wr), .per_data_i(per_d),
    .duty_wr_i(duty_wr), .duty_coarse_i(dc), .duty_fine_i(df),
    .ustep_wr_i(us_wr), .ustep_data_i(us_d),
    .pwm_o(pwm), .period_start_o(ps)
  );

  // behavioural reference model, one update per rising edge
  int m_rs, m_cnt, m_pact, m_dact, m_psh, m_dsh;
  bit m_run;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs = 0; m_cnt = 0; m_run = 0;
      m_pact = 255; m_psh = 255; m_dact = 0; m_dsh = 0;
    end else if (m_rs < 2) begin
      m_rs++;
    end else begin
      int npsh, ndsh;
      bit ld;
      npsh = per_wr ? int'(per_d) : m_psh;
      if (duty_wr)    ndsh = int'(dc) * 4 + int'(df);
      else if (us_wr) ndsh = (int'(us_d) / 2) * 4 + (int'(us_d) % 2) * 2;
      else            ndsh = m_dsh;
      ld = !m_run || (m_cnt == m_pact * 4 + 3);
      if (ld) begin
        m_pact = m_psh; m_dact = m_dsh;
      end
      if (!en || ld) m_cnt = 0;
      else           m_cnt = m_cnt + 1;
      m_run = en;
      m_psh = npsh; m_dsh = ndsh;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(pwm == (m_run && m_cnt < m_dact), "R3 model pwm", pwm, int'(m_run && m_cnt < m_dact));
    chk(ps == (m_run && m_cnt == 0), "R10 model marker", ps, int'(m_run && m_cnt == 0));
  end

  task automatic wr_per(input int p);
    per_d = 8'(p); per_wr = 1; @(negedge clk); per_wr = 0;
  endtask
  task automatic wr_duty(input int c, input int f);
    dc = 8'(c); df = 2'(f); duty_wr = 1; @(negedge clk); duty_wr = 0;
  endtask
  task automatic wr_step(input int u);
    us_d = 8'(u); us_wr = 1; @(negedge clk); us_wr = 0;
  endtask
  task automatic to_start();
    do @(negedge clk); while (!ps);
  endtask
  // from a marker clock, measure one period; ends on the next marker
  task automatic measure(output int len, output int hi);
    len = 0; hi = 0;
    do begin
      if (pwm) hi++;
      len++;
      @(negedge clk);
    end while (!ps);
  endtask
  task automatic per_check(input string tag, input int elen, input int ehi);
    int len, hi;
    to_start();
    measure(len, hi);
    chk(len == elen, {tag, " length"}, len, elen);
    chk(hi == ehi, {tag, " high"}, hi, ehi);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pwm == 0 && ps == 0, "R1 reset outputs", {pwm, ps}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(pwm == 0 && ps == 0, "R1 idle outputs", {pwm, ps}, 0);
    wr_duty(8'h40, 0);
    en = 1;
    per_check("R1 default top", 1024, 256);
    wr_per(8'h7C); wr_duty(8'h30, 2);
    per_check("R3 R2 top 0x7C", 500, 194);
    for (int f = 0; f < 4; f++) begin
      wr_duty(8'h30, f);
      per_check("R6 fine step", 500, 192 + f);
    end
    wr_duty(0, 0);
    per_check("R5 zero duty", 500, 0);
    wr_duty(8'h7D, 0);
    per_check("R4 one past top", 500, 500);
    wr_duty(8'hFF, 3);
    per_check("R4 max duty", 500, 500);
    wr_duty(8'h7C, 3);
    per_check("R3 last count", 500, 499);
    wr_step(250);
    per_check("R8 step 250", 500, 500);
    wr_step(101);
    per_check("R8 step 101", 500, 202);
    dc = 8'h10; df = 2'd1; us_d = 8'd200; duty_wr = 1; us_wr = 1;
    @(negedge clk); duty_wr = 0; us_wr = 0;
    per_check("R11 direct wins", 500, 65);
    // R7: rewrite in the low part of a period
    wr_duty(8'h30, 0);
    to_start(); to_start();
    repeat (250) @(negedge clk);
    wr_duty(8'hFF, 3);
    begin
      int hi = 0;
      while (!ps) begin
        if (pwm) hi++;
        @(negedge clk);
      end
      chk(hi == 0, "R7 rest of period", hi, 0);
    end
    begin
      int len, hi;
      measure(len, hi);
      chk(hi == 500, "R7 next period", hi, 500);
    end
    wr_per(0); wr_duty(0, 3);
    per_check("R2 shortest top", 4, 3);
    per_check("R2 shortest again", 4, 3);
    // R9: stop mid-period with output high, then restart
    wr_per(8'h7C); wr_duty(8'h30, 0);
    to_start(); to_start();
    @(negedge clk);
    en = 0;
    @(negedge clk);
    chk(pwm == 0 && ps == 0, "R9 stopped", {pwm, ps}, 0);
    repeat (5) @(negedge clk);
    chk(pwm == 0 && ps == 0, "R9 still stopped", {pwm, ps}, 0);
    en = 1;
    @(negedge clk);
    chk(ps == 1 && pwm == 1, "R9 R10 restart", {pwm, ps}, 3);
    @(negedge clk);
    chk(ps == 0, "R10 marker one clock", ps, 0);
    begin
      int len, hi;
      to_start();
      measure(len, hi);
      chk(len == 500 && hi == 192, "R9 after restart", hi, 192);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule